// File: doc/BRIEF.md
# Memory-Mapped Console Character Port

This block gives a processor access to a keyboard and a screen through ordinary loads and stores. It answers inside a small address window at the top of the address space. Four word-wide slots in that window carry the state and the data of an input channel (keyboard) and an output channel (screen). Software polls a ready flag in each channel's control word, or sets that channel's interrupt-enable bit and waits for the matching interrupt line.

On the device side, each arriving keyboard byte comes with a one-cycle valid strobe and is always accepted. Outgoing screen bytes use a valid/ready handshake: the byte is held on the output until the sink accepts it. Bus accesses finish in a single cycle. Read data is combinational from the current address, and side effects take hold at the clock edge that ends the access.

Top module: `console_mmio`

## Requirements
- R1: Mapped slots, all word-aligned: input control at 0xFFFF0000, input data at 0xFFFF0004, output control at 0xFFFF0008, output data at 0xFFFF000C. Control words read as {30'b0, enable (bit 1), ready (bit 0)}. The output data slot reads as zero.
- R2: A cycle with kb_valid high sets the input ready flag and captures kb_byte at that clock edge.
- R3: A read of the input data slot returns the held byte in bits 7:0 with zeros above, and clears input ready at the end of the access.
- R4: A byte that arrives while input ready is still set replaces the held byte, and ready stays set.
- R5: The output ready flag is 1 whenever no byte is waiting for the sink.
- R6: A write to the output data slot while output ready is 1 drives wdata[7:0] on scr_byte with scr_valid high from the next cycle, and output ready reads 0.
- R7: scr_valid and scr_byte hold steady until scr_ready is high. The cycle after that handshake, scr_valid is low and output ready is 1.
- R8: A write to the output data slot while output ready is 0 has no effect: the pending byte is unchanged and no extra byte is sent.
- R9: Only bit 1 (enable) of a control word is writable. Writing bit 0 does not change the ready flag.
- R10: irq[0] is high exactly when output ready and output enable are both 1. irq[1] is high exactly when input ready and input enable are both 1.
- R11: Offsets 0x10 to 0xFF of the window, misaligned addresses, and addresses outside the window read as zero and ignore writes.
- R12: After reset: both enables 0, input ready 0, output ready 1, scr_valid 0, irq 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = store, 0 = load |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Load data (combinational) |
| kb_valid | input | 1 | Keyboard byte strobe |
| kb_byte | input | 8 | Keyboard byte |
| scr_valid | output | 1 | Screen byte offered |
| scr_byte | output | 8 | Screen byte |
| scr_ready | input | 1 | Screen sink accepts byte |
| irq | output | 2 | bit 0 output channel, bit 1 input channel |

## Verification
The output channel is driven in three ways: with the sink stalled, so that the held byte and the ignored second write can be told apart; with the sink always ready; and with back-to-back writes that poll the ready flag, which exposes an early or late return of ready. A scoreboard lines up every byte handed to the sink against the bytes written while ready. The input channel gets a single byte, two bytes without a read in between (overwrite against keep-first), and a byte with the interrupt enabled. Stores and loads to unmapped, misaligned and out-of-window addresses are followed by reads of the real slots. These catch decoders that ignore upper or lower address bits.

// File: rtl/console_pkg.sv
package console_pkg;
    localparam int BYTE_W    = 8;
    localparam int NUM_SLOTS = 4;
    localparam int BIT_READY = 0;
    localparam int BIT_IE    = 1;

    typedef enum logic [1:0] {
        SLOT_RX_CTRL = 2'd0,
        SLOT_RX_DATA = 2'd1,
        SLOT_TX_CTRL = 2'd2,
        SLOT_TX_DATA = 2'd3
    } slot_e;

    typedef struct packed {
        logic              rdy;
        logic              ie;
        logic [BYTE_W-1:0] data;
    } rx_state_t;

    typedef struct packed {
        logic              pend;
        logic              ie;
        logic [BYTE_W-1:0] data;
    } tx_state_t;
endpackage

// File: rtl/console_decode.sv
module console_decode
    import console_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'hFFFF_0000,
    parameter int          WIN_BITS  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic [31:0]          addr,
    output logic [NUM_SLOTS-1:0] sel
);
    logic                in_window;
    logic [WIN_BITS-1:0] offset;

    assign in_window = req && (addr[31:WIN_BITS] == BASE_ADDR[31:WIN_BITS]);
    assign offset    = addr[WIN_BITS-1:0];

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        assign sel[i] = in_window && (offset == WIN_BITS'(4 * i));
    end

    // R11: at most one slot responds, and none without a request
    a_r11_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel) && (!req -> sel == '0));
endmodule

// File: rtl/console_rx.sv
module console_rx
    import console_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              ctrl_wr,
    input  logic              ie_wdata,
    input  logic              data_rd,
    output logic              rdy,
    output logic              ie,
    output logic [BYTE_W-1:0] data
);
    rx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctrl_wr) begin
            st_d.ie = ie_wdata;
        end
        if (data_rd) begin
            st_d.rdy = 1'b0;
        end
        if (in_valid) begin
            st_d.rdy  = 1'b1;
            st_d.data = in_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdy  = st_q.rdy;
    assign ie   = st_q.ie;
    assign data = st_q.data;

    a_r2_arrival_captured: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (rdy && data == $past(in_byte)));
    a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !in_valid) |=> !rdy);
    a_r9_ready_only_by_arrival: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> $past(in_valid));
endmodule

// File: rtl/console_tx.sv
module console_tx
    import console_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              ie_wdata,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] wbyte,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte,
    input  logic              out_ready,
    output logic              rdy,
    output logic              ie
);
    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctrl_wr) begin
            st_d.ie = ie_wdata;
        end
        if (st_q.pend) begin
            if (out_ready) begin
                st_d.pend = 1'b0;
            end
        end else if (data_wr) begin
            st_d.pend = 1'b1;
            st_d.data = wbyte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.pend;
    assign out_byte  = st_q.data;
    assign rdy       = !st_q.pend;
    assign ie        = st_q.ie;

    a_r6_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && rdy) |=> (out_valid && out_byte == $past(wbyte)));
    a_r7_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));
    a_r8_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !rdy) |=> $stable(out_byte));
endmodule

// File: rtl/console_mmio.sv
module console_mmio
    import console_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'hFFFF_0000,
    parameter int          WIN_BITS  = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_req,
    input  logic        bus_we,
    input  logic [31:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        kb_valid,
    input  logic [7:0]  kb_byte,
    output logic        scr_valid,
    output logic [7:0]  scr_byte,
    input  logic        scr_ready,
    output logic [1:0]  irq
);
    logic [NUM_SLOTS-1:0] sel;
    logic                 rx_rdy, rx_ie, tx_rdy, tx_ie;
    logic [BYTE_W-1:0]    rx_data;
    logic                 rx_ctrl_wr, rx_data_rd, tx_ctrl_wr, tx_data_wr;
    logic                 unused_wbits;

    assign unused_wbits = ^bus_wdata[31:BYTE_W];

    console_decode #(.BASE_ADDR(BASE_ADDR), .WIN_BITS(WIN_BITS)) u_decode (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (bus_req),
        .addr (bus_addr),
        .sel  (sel)
    );

    assign rx_ctrl_wr = sel[SLOT_RX_CTRL] &&  bus_we;
    assign rx_data_rd = sel[SLOT_RX_DATA] && !bus_we;
    assign tx_ctrl_wr = sel[SLOT_TX_CTRL] &&  bus_we;
    assign tx_data_wr = sel[SLOT_TX_DATA] &&  bus_we;

    console_rx u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(kb_valid),
        .in_byte (kb_byte),
        .ctrl_wr (rx_ctrl_wr),
        .ie_wdata(bus_wdata[BIT_IE]),
        .data_rd (rx_data_rd),
        .rdy     (rx_rdy),
        .ie      (rx_ie),
        .data    (rx_data)
    );

    console_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (tx_ctrl_wr),
        .ie_wdata (bus_wdata[BIT_IE]),
        .data_wr  (tx_data_wr),
        .wbyte    (bus_wdata[BYTE_W-1:0]),
        .out_valid(scr_valid),
        .out_byte (scr_byte),
        .out_ready(scr_ready),
        .rdy      (tx_rdy),
        .ie       (tx_ie)
    );

    always_comb begin
        bus_rdata = '0;
        if (!bus_we) begin
            if (sel[SLOT_RX_CTRL]) bus_rdata = {30'b0, rx_ie, rx_rdy};
            if (sel[SLOT_RX_DATA]) bus_rdata = {{(32-BYTE_W){1'b0}}, rx_data};
            if (sel[SLOT_TX_CTRL]) bus_rdata = {30'b0, tx_ie, tx_rdy};
        end
    end

    assign irq[0] = tx_rdy && tx_ie;
    assign irq[1] = rx_rdy && rx_ie;

    // R10: the input line only rises after an arrival or an enable write
    a_r10_rx_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq[1]) |-> ($past(kb_valid) || $past(rx_ctrl_wr)));
    // R10: the output line only rises after a handshake or an enable write
    a_r10_tx_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq[0]) |-> ($past(scr_valid && scr_ready) || $past(tx_ctrl_wr)));
endmodule

// File: tb/tb_console_mmio.sv
module tb_console_mmio;
    localparam logic [31:0] A_RXC = 32'hFFFF_0000;
    localparam logic [31:0] A_RXD = 32'hFFFF_0004;
    localparam logic [31:0] A_TXC = 32'hFFFF_0008;
    localparam logic [31:0] A_TXD = 32'hFFFF_000C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        kb_valid = 1'b0;
    logic [7:0]  kb_byte = '0;
    logic        scr_valid;
    logic [7:0]  scr_byte;
    logic        scr_ready = 1'b0;
    logic [1:0]  irq;

    int checks = 0, fails = 0;
    logic sink_en = 1'b0;
    logic [7:0] exp_q[$];

    always #10 clk = ~clk;

    console_mmio dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .kb_valid(kb_valid), .kb_byte(kb_byte), .scr_valid(scr_valid),
        .scr_byte(scr_byte), .scr_ready(scr_ready), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    // driver: write a byte to the output slot and expect it at the sink
    task automatic send_byte(input logic [7:0] b);
        exp_q.push_back(b);
        bus_write(A_TXD, {24'hABCDEF, b});
    endtask

    task automatic kb_send(input logic [7:0] b);
        @(negedge clk);
        kb_valid = 1'b1; kb_byte = b;
        @(negedge clk);
        kb_valid = 1'b0;
    endtask

    // sink: ready pattern set at falling edges
    always @(negedge clk) scr_ready <= sink_en;

    // monitor: a handshake at the coming rising edge pops the scoreboard
    always @(negedge clk) begin
        #2;
        if (rst_n && scr_valid && scr_ready) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R8 actual=%h expected=none (unexpected byte)", scr_byte);
            end else begin
                check("R6 R7 sink byte", {24'b0, scr_byte}, {24'b0, exp_q.pop_front()});
            end
        end
    end

    initial begin
        #(200000 * 20);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 / R1 reset state and map
        #1 check("R12 irq", {30'b0, irq}, 0);
        check("R12 scr_valid", {31'b0, scr_valid}, 0);
        bus_read(A_RXC, r); check("R12 R1 rx ctrl", r, 0);
        bus_read(A_RXD, r); check("R1 rx data", r, 0);
        bus_read(A_TXC, r); check("R12 R5 tx ctrl", r, 1);
        bus_read(A_TXD, r); check("R1 tx data reads zero", r, 0);

        // R9 only enable writable
        bus_write(A_RXC, 32'h1); bus_read(A_RXC, r); check("R9 ready not writable", r, 0);
        bus_write(A_RXC, 32'hFFFF_FFFF); bus_read(A_RXC, r); check("R9 enable writable", r, 2);
        bus_write(A_RXC, 32'h0);

        // R2 R3 single arrival
        kb_send(8'h41);
        bus_read(A_RXC, r); check("R2 ready set", r, 1);
        bus_read(A_RXD, r); check("R3 data zero-extended", r, 32'h41);
        bus_read(A_RXC, r); check("R3 ready cleared", r, 0);

        // R4 overwrite
        kb_send(8'h10); kb_send(8'hFE);
        bus_read(A_RXD, r); check("R4 newest byte kept", r, 32'hFE);

        // R10 input interrupt
        bus_write(A_RXC, 32'h2);
        #1 check("R10 rx irq idle", {30'b0, irq}, 0);
        kb_send(8'h55);
        #1 check("R10 rx irq raised", {30'b0, irq}, 2);
        bus_read(A_RXD, r); check("R3 data", r, 32'h55);
        #1 check("R10 rx irq cleared", {30'b0, irq}, 0);
        bus_write(A_RXC, 32'h0);

        // R6 R7 R8 stalled sink
        send_byte(8'hA5);
        #1 check("R6 scr_valid", {31'b0, scr_valid}, 1);
        check("R6 scr_byte", {24'b0, scr_byte}, 32'hA5);
        bus_read(A_TXC, r); check("R6 ready low", r, 0);
        bus_write(A_TXD, 32'h33);
        #1 check("R8 byte unchanged", {24'b0, scr_byte}, 32'hA5);
        bus_write(A_TXC, 32'h2);
        #1 check("R10 tx irq needs ready", {30'b0, irq}, 0);
        repeat (4) @(negedge clk);
        #1 check("R7 held while stalled", {23'b0, scr_valid, scr_byte}, 32'h1A5);
        sink_en = 1'b1;
        repeat (3) @(negedge clk);
        #1 check("R7 released", {31'b0, scr_valid}, 0);
        check("R10 tx irq", {30'b0, irq}, 1);
        bus_read(A_TXC, r); check("R5 ready back", r, 3);
        check("R8 no extra byte queued", exp_q.size(), 0);

        // R7 back-to-back with polling, sink always ready
        for (int i = 0; i < 6; i++) begin
            send_byte(8'(8'h60 + i));
            bus_read(A_TXC, r);
            check("R7 ready after one-cycle handshake", r, 3);
        end
        bus_write(A_TXC, 32'h0);

        // R11 unmapped accesses
        kb_send(8'h77);
        bus_read(32'hFFFF_0010, r); check("R11 unmapped offset reads zero", r, 0);
        bus_read(32'hFFFF_0001, r); check("R11 misaligned reads zero", r, 0);
        bus_read(32'hFFFE_0000, r); check("R11 outside window reads zero", r, 0);
        bus_write(32'hFFFF_0014, 32'h2);
        bus_write(32'hFFFE_0008, 32'h2);
        bus_write(32'hFFFF_0108, 32'h2);
        bus_write(32'hFFFF_000D, 32'h99);
        bus_read(A_RXC, r); check("R11 rx ctrl untouched", r, 1);
        bus_read(A_TXC, r); check("R11 tx ctrl untouched", r, 1);
        #1 check("R11 no byte launched", {31'b0, scr_valid}, 0);
        bus_read(A_RXD, r); check("R3 final read", r, 32'h77);

        repeat (3) @(negedge clk);
        check("R6 scoreboard drained", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule